// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Port

This block is the serial slave port of one device in a vertical stack of identical monitors. Its lower side connects to the host, or to the device below. Its upper side relays chip select, clock and data to the device above and takes that device's returned data. The serial link uses clock polarity 1 and clock phase 1. Input data is sampled on each rising clock edge, and output data changes after each falling edge. All serial pins are sampled by the block's system clock, which must run well above the serial bit rate (serial clock up to 1 MHz).

A transfer starts when chip select falls. The first byte is a command. A configuration write streams six bytes per device through the whole chain, with the top device's bytes first. Each device keeps the last six bytes it saw and passes the earlier ones upward through a 48-bit delay. A configuration read shifts out the local six bytes and a CRC-8 check byte. Meanwhile the clock to the device above is held, and it is released afterwards so that the upper device's bytes follow. A top-of-stack input marks the uppermost device, which has no upper neighbour.

The control is a state machine with these states: IDLE, CMD (collecting the command byte), WR_CFG (config write), RD_LOCAL (local read data), RD_FWD (relaying upper data) and PASS (unknown command). The transitions are:
- IDLE→CMD when chip select falls.
- CMD→WR_CFG, CMD→RD_LOCAL or CMD→PASS on the eighth rising clock edge, chosen by the command value.
- RD_LOCAL→RD_FWD on the falling edge that follows the last local bit.
- Any state→IDLE whenever chip select is high.

Top module: `chain_spi_port`

## Requirements
- R1: After reset, `cfg_o` is zero, `sdo_lo_o` is 1, and (with chip select in high) `csb_up_o` is 1.
- R2: Input bits are taken on rising edges of `sck_lo_i`. `sdo_lo_o` changes only while the serial clock is low or chip select is high.
- R3: On a device that is not the top, `csb_up_o` follows `csb_lo_i`, and the command byte is relayed upward unchanged, bit for bit.
- R4: Command 0x01 is a configuration write. When chip select rises, the last six whole bytes received are stored: the first of those six goes to `cfg_o[7:0]` and the last goes to `cfg_o[47:40]`.
- R5: During a write, each configuration bit leaves on `sdi_up_o` 48 rising edges after it arrived. The first 48 forwarded bits are ones.
- R6: A write with fewer than 48 configuration bits, or with a bit count that is not a multiple of 8, leaves `cfg_o` unchanged.
- R7: `cfg_o` changes only once chip select has returned high. It is unchanged at the end of a write that is still in progress.
- R8: Command 0x02 is a configuration read. After the command byte, `sdo_lo_o` gives `cfg_o[7:0]` first and `cfg_o[47:40]` last, each byte MSB first, followed by the check byte.
- R9: The check byte is a CRC-8 with polynomial x^8+x^2+x+1 and initial value 0x41, computed MSB first over the six read bytes.
- R10: During a read on a device that is not the top, `sck_up_o` stays high while the 56 local bits are shifted out. The host clocks are then relayed, and `sdo_lo_o` returns `sdo_up_i`, so the upper device's first bit appears right after the local check byte.
- R11: With `top_i` high, `csb_up_o`, `sck_up_o` and `sdi_up_o` stay high, writes keep the last six bytes, and a read returns ones after the check byte.
- R12: Any other command leaves `cfg_o` unchanged. All bits are relayed upward undelayed, and `sdo_lo_o` returns `sdo_up_i` from the first bit after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| top_i | input | 1 | High on the uppermost device of the stack |
| csb_lo_i | input | 1 | Chip select from below, active low |
| sck_lo_i | input | 1 | Serial clock from below, idles high |
| sdi_lo_i | input | 1 | Serial data from below |
| sdo_lo_o | output | 1 | Serial data returned downward |
| csb_up_o | output | 1 | Chip select relayed upward |
| sck_up_o | output | 1 | Serial clock relayed upward, held high during local read |
| sdi_up_o | output | 1 | Serial data relayed upward |
| sdo_up_i | input | 1 | Serial data returned by the device above |
| cfg_o | output | 48 | Six stored configuration bytes, byte k at bits 8k+7:8k |

## Verification
The bench models the upper neighbour and the host behaviourally, and compares `cfg_o` and the relayed chip select on every clock. It targets the following corner cases and the failure each would show:
- Multi-frame writes. A device that kept the first six bytes instead of the last, or forwarded without the 48-bit delay, would store the top device's bytes and break the stream the upper device sees.
- Short and misaligned writes. A design that latched on any chip-select rise would corrupt `cfg_o`.
- Reads. An off-by-one in the clock hold window would drop or repeat the upper device's first bit, and a wrong CRC seed or bit order changes the check byte.
- The top-of-stack case and an unknown command. These expose a block that still clocks a missing neighbour or misroutes relayed data.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR_CFG,
        ST_RD_LOCAL,
        ST_RD_FWD,
        ST_PASS
    } port_state_e;

    // One MSB-first CRC-8 step.
    function automatic logic [7:0] crc8_bit(input logic [7:0] crc,
                                            input logic       din,
                                            input logic [7:0] poly);
        logic       fb;
        logic [7:0] nxt;
        fb  = crc[7] ^ din;
        nxt = {crc[6:0], 1'b0};
        return fb ? (nxt ^ poly) : nxt;
    endfunction

endpackage

// File: rtl/chain_sck_edge.sv
module chain_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic rise_o,
    output logic fall_o
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b1;
        else        sck_q <= sck_i;
    end

    assign rise_o = sck_i & ~sck_q;
    assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/chain_cfg_shift.sv
module chain_cfg_shift #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         din_i,
    output logic [W-1:0] data_o
);
    logic [W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sreg_q <= '1;
        else if (clr_i) sreg_q <= '1;
        else if (en_i)  sreg_q <= {sreg_q[W-2:0], din_i};
    end

    assign data_o = sreg_q;
endmodule

// File: rtl/chain_tx_shift.sv
module chain_tx_shift #(
    parameter int W = 56
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         shift_i,
    output logic         msb_o
);
    logic [W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_q <= '1;
        else if (load_i)  tx_q <= word_i;
        else if (shift_i) tx_q <= {tx_q[W-2:0], 1'b1};
    end

    assign msb_o = tx_q[W-1];
endmodule

// File: rtl/chain_pec.sv
module chain_pec
    import chain_spi_pkg::*;
#(
    parameter int         W    = 48,
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'h41
) (
    input  logic [W-1:0] data_i,
    output logic [7:0]   pec_o
);
    always_comb begin
        logic [7:0] acc;
        acc = INIT;
        for (int i = W - 1; i >= 0; i--) begin
            acc = crc8_bit(acc, data_i[i], POLY);
        end
        pec_o = acc;
    end
endmodule

// File: rtl/chain_spi_port.sv
module chain_spi_port
    import chain_spi_pkg::*;
#(
    parameter int         CFG_BYTES = 6,
    parameter int         CNT_W     = 12,
    parameter logic [7:0] CMD_WR    = 8'h01,
    parameter logic [7:0] CMD_RD    = 8'h02,
    parameter logic [7:0] PEC_POLY  = 8'h07,
    parameter logic [7:0] PEC_INIT  = 8'h41
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   top_i,
    input  logic                   csb_lo_i,
    input  logic                   sck_lo_i,
    input  logic                   sdi_lo_i,
    output logic                   sdo_lo_o,
    output logic                   csb_up_o,
    output logic                   sck_up_o,
    output logic                   sdi_up_o,
    input  logic                   sdo_up_i,
    output logic [CFG_BYTES*8-1:0] cfg_o
);
    localparam int CFG_W = CFG_BYTES * 8;
    localparam int RD_W  = CFG_W + 8;

    port_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [7:0]        cmd_q;
    logic [7:0]        cmd_next;
    logic              gate_q;
    logic              out_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [CFG_W-1:0]  shreg;
    logic [CFG_W-1:0]  cfg_capt;
    logic [CFG_W-1:0]  cfg_stream;
    logic [7:0]        pec;
    logic              rise, fall;
    logic              cmd_done;
    logic              wr_ok;
    logic              tx_msb;
    logic              tx_load, tx_shift;
    logic              rd_last;

    chain_sck_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck_lo_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    chain_cfg_shift #(.W(CFG_W)) u_cfg_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q == ST_IDLE),
        .en_i   ((state_q == ST_WR_CFG) && rise),
        .din_i  (sdi_lo_i),
        .data_o (shreg)
    );

    // Byte remapping between serial order and register order
    for (genvar k = 0; k < CFG_BYTES; k++) begin : g_map
        assign cfg_capt[8*k +: 8]             = shreg[CFG_W-1-8*k -: 8];
        assign cfg_stream[CFG_W-1-8*k -: 8]   = cfg_q[8*k +: 8];
    end

    chain_pec #(.W(CFG_W), .POLY(PEC_POLY), .INIT(PEC_INIT)) u_pec (
        .data_i (cfg_stream),
        .pec_o  (pec)
    );

    chain_tx_shift #(.W(RD_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tx_load),
        .word_i  ({cfg_stream, pec}),
        .shift_i (tx_shift),
        .msb_o   (tx_msb)
    );

    assign cmd_next = {cmd_q[6:0], sdi_lo_i};
    assign cmd_done = (state_q == ST_CMD) && rise && (cnt_q == CNT_W'(7));
    assign wr_ok    = (cnt_q >= CNT_W'(CFG_W)) && (cnt_q[2:0] == 3'd0);
    assign rd_last  = (cnt_q == CNT_W'(RD_W));
    assign tx_load  = cmd_done && (cmd_next == CMD_RD);
    assign tx_shift = (state_q == ST_RD_LOCAL) && fall && !rd_last && !csb_lo_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (csb_lo_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_CMD;
                ST_CMD: begin
                    if (cmd_done) begin
                        if (cmd_next == CMD_WR)      state_d = ST_WR_CFG;
                        else if (cmd_next == CMD_RD) state_d = ST_RD_LOCAL;
                        else                         state_d = ST_PASS;
                    end
                end
                ST_WR_CFG:   state_d = ST_WR_CFG;
                ST_RD_LOCAL: if (fall && rd_last) state_d = ST_RD_FWD;
                ST_RD_FWD:   state_d = ST_RD_FWD;
                ST_PASS:     state_d = ST_PASS;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmd_q  <= '0;
            gate_q <= 1'b0;
            out_q  <= 1'b1;
            cfg_q  <= '0;
        end else if (csb_lo_i) begin
            cnt_q  <= '0;
            gate_q <= 1'b0;
            out_q  <= 1'b1;
            if ((state_q == ST_WR_CFG) && wr_ok) cfg_q <= cfg_capt;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    cmd_q <= '0;
                end
                ST_CMD: begin
                    if (rise) begin
                        cmd_q <= cmd_next;
                        cnt_q <= cmd_done ? '0 : cnt_q + 1'b1;
                        if (tx_load) gate_q <= 1'b1;
                    end
                end
                ST_WR_CFG: begin
                    if (rise && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
                end
                ST_RD_LOCAL: begin
                    if (fall) begin
                        if (rd_last) begin
                            gate_q <= 1'b0;
                        end else begin
                            out_q <= tx_msb;
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sdo_lo_o = 1'b1;
        sdi_up_o = sdi_lo_i;
        unique case (state_q)
            ST_WR_CFG:          sdi_up_o = shreg[CFG_W-1];
            ST_RD_LOCAL:        sdo_lo_o = out_q;
            ST_RD_FWD, ST_PASS: sdo_lo_o = top_i ? 1'b1 : sdo_up_i;
            default: ;
        endcase
        if (top_i) sdi_up_o = 1'b1;
        csb_up_o = top_i | csb_lo_i;
        sck_up_o = top_i | gate_q | sck_lo_i;
    end

    assign cfg_o = cfg_q;

    AST_SDO_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_lo_i && $past(sck_lo_i) && !csb_lo_i && !$past(csb_lo_i)) |-> $stable(sdo_lo_o))
        else $error("sdo changed while clock high"); // R2

    AST_CFG_ONLY_AT_CSB: assert property (@(posedge clk) disable iff (!rst_n)
        !csb_lo_i |=> $stable(cfg_o))
        else $error("cfg changed with chip select low"); // R7

    AST_GATE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RD_LOCAL) |-> !gate_q)
        else $error("upper clock held outside local read"); // R10

    AST_CMD_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD) |-> (cnt_q < CNT_W'(8)))
        else $error("command bit count overflow"); // R3

    AST_RD_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_LOCAL) |-> (cnt_q <= CNT_W'(RD_W)))
        else $error("read bit count overflow"); // R8

endmodule

// File: tb/chain_spi_port_bench.sv
`timescale 1ns/1ps
module chain_spi_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        top_tie = 1'b0;
    logic        csb_lo = 1'b1;
    logic        sck_lo = 1'b1;
    logic        sdi_lo = 1'b1;
    logic        sdo_lo_o;
    logic        csb_up_o, sck_up_o, sdi_up_o;
    logic        sdo_up_i = 1'b1;
    logic [47:0] cfg_o;

    always #10 clk = ~clk;

    chain_spi_port u_chain_spi_port (
        .clk(clk), .rst_n(rst_n), .top_i(top_tie),
        .csb_lo_i(csb_lo), .sck_lo_i(sck_lo), .sdi_lo_i(sdi_lo), .sdo_lo_o(sdo_lo_o),
        .csb_up_o(csb_up_o), .sck_up_o(sck_up_o), .sdi_up_o(sdi_up_o),
        .sdo_up_i(sdo_up_i), .cfg_o(cfg_o)
    );

    int checks = 0, errs = 0, pc_checks = 0, pc_err = 0;
    logic [47:0] exp_cfg = '0, pend_cfg = '0;
    bit pend_valid = 0;
    bit host_tx[$], host_rx[$], exp_q[$];
    logic [7:0] frm[$];

    // Upper neighbour model
    bit up_tx_mem [0:63];
    bit up_rx[$];
    int up_rises = 0, up_falls = 0, up_idx = 0;

    always @(posedge sck_up_o) if (!csb_up_o) begin
        up_rx.push_back(sdi_up_o);
        up_rises++;
    end

    always @(negedge sck_up_o or posedge csb_up_o) begin
        if (csb_up_o) begin
            sdo_up_i = 1'b1; up_falls = 0; up_idx = 0;
        end else begin
            up_falls++;
            if (up_falls > 8) begin
                sdo_up_i = (up_idx < 64) ? up_tx_mem[up_idx] : 1'b1;
                up_idx++;
            end
        end
    end

    // Per-clock reference comparison
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            pc_checks++;
            if (cfg_o !== exp_cfg) begin
                pc_err++;
                $display("FAIL R4 R7 cfg_o: got %h expected %h", cfg_o, exp_cfg);
            end
            pc_checks++;
            if (top_tie && !(csb_up_o && sck_up_o && sdi_up_o)) begin
                pc_err++;
                $display("FAIL R11 upper outputs: got %b%b%b expected 111", csb_up_o, sck_up_o, sdi_up_o);
            end else if (!top_tie && csb_up_o !== csb_lo) begin
                pc_err++;
                $display("FAIL R3 csb_up_o: got %b expected %b", csb_up_o, csb_lo);
            end
        end
    end

    task automatic chk(input string req, input bit ok, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic cmp_bits(input string req, input string what,
                            input bit got[$], input int off, input bit expq[$]);
        int bad;
        bad = -1;
        if (got.size() < off + expq.size()) bad = -2;
        else for (int i = 0; i < expq.size(); i++)
            if (bad == -1 && got[off+i] != expq[i]) bad = i;
        checks++;
        if (bad != -1) begin
            errs++;
            if (bad == -2)
                $display("FAIL %s %s: got %0d bits expected %0d bits", req, what, got.size(), off + expq.size());
            else
                $display("FAIL %s %s bit %0d: got %0d expected %0d", req, what, bad, got[off+bad], expq[bad]);
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) host_tx.push_back(b[i]);
    endtask

    task automatic push_exp(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    function automatic logic [7:0] ref_pec(input logic [47:0] c);
        logic [7:0] r;
        r = 8'h41;
        for (int k = 0; k < 6; k++)
            for (int i = 7; i >= 0; i--) begin
                logic fb;
                fb = r[7] ^ c[8*k+i];
                r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        return r;
    endfunction

    task automatic spi_run();
        host_rx.delete();
        @(negedge clk) csb_lo = 1'b0;
        repeat (4) @(negedge clk);
        foreach (host_tx[i]) begin
            sck_lo = 1'b0; sdi_lo = host_tx[i];
            repeat (4) @(negedge clk);
            host_rx.push_back(sdo_lo_o);
            sck_lo = 1'b1;
            repeat (4) @(negedge clk);
        end
        chk("R7", cfg_o === exp_cfg, "cfg_o before chip select rise", cfg_o, exp_cfg);
        csb_lo = 1'b1;
        if (pend_valid) begin exp_cfg = pend_cfg; pend_valid = 0; end
        repeat (4) @(negedge clk);
    endtask

    // Write of the bytes in frm plus extra zero bits; keep marks a valid frame
    task automatic write_cfg(input int extra, input bit keep);
        int n, base, rb;
        host_tx.delete();
        push_tx(8'h01);
        foreach (frm[i]) push_tx(frm[i]);
        for (int i = 0; i < extra; i++) host_tx.push_back(1'b0);
        n = frm.size();
        if (keep) begin
            for (int k = 0; k < 6; k++) pend_cfg[8*k +: 8] = frm[n-6+k];
            pend_valid = 1;
        end
        base = up_rx.size(); rb = up_rises;
        spi_run();
        if (top_tie) begin
            chk("R11", up_rises == rb, "upper clock rises on top write", up_rises - rb, 0);
        end else begin
            exp_q.delete();
            for (int i = 0; i < 8; i++) exp_q.push_back(host_tx[i]);
            for (int m = 0; m < host_tx.size() - 8; m++)
                exp_q.push_back(m < 48 ? 1'b1 : host_tx[8+m-48]);
            cmp_bits("R3 R5", "upward write stream", up_rx, base, exp_q);
        end
    endtask

    task automatic read_cfg();
        int rb;
        host_tx.delete();
        push_tx(8'h02);
        for (int i = 0; i < 112; i++) host_tx.push_back(1'b1);
        rb = up_rises;
        spi_run();
        exp_q.delete();
        for (int i = 0; i < 8; i++) exp_q.push_back(1'b1);
        for (int k = 0; k < 6; k++) push_exp(exp_cfg[8*k +: 8]);
        push_exp(ref_pec(exp_cfg));
        for (int i = 0; i < 56; i++) exp_q.push_back(top_tie ? 1'b1 : up_tx_mem[i]);
        cmp_bits(top_tie ? "R2 R8 R9 R11" : "R2 R8 R9 R10", "read stream", host_rx, 0, exp_q);
        if (!top_tie)
            chk("R10", up_rises - rb == 64, "upper clock rises during read", up_rises - rb, 64);
    endtask

    initial begin : main
        for (int i = 0; i < 64; i++) up_tx_mem[i] = bit'((((i * 37) + 11) >> 2) & 1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", cfg_o === 48'h0, "cfg_o after reset", cfg_o, 0);
        chk("R1", sdo_lo_o === 1'b1, "sdo_lo_o after reset", sdo_lo_o, 1);
        chk("R1", csb_up_o === 1'b1, "csb_up_o after reset", csb_up_o, 1);

        // single-device frame
        frm = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6};
        write_cfg(0, 1);
        chk("R4", cfg_o[7:0] === 8'hA1, "first kept byte", cfg_o[7:0], 8'hA1);

        // three-device stream: bottom keeps the last six
        frm = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66,
                8'h77, 8'h88, 8'h99, 8'hAA, 8'hBB, 8'hCC,
                8'h3C, 8'h5A, 8'h96, 8'h0F, 8'hF0, 8'h81};
        write_cfg(0, 1);
        chk("R4", cfg_o === 48'h81F0_0F96_5A3C, "cfg after 3 frames", cfg_o, 48'h81F0_0F96_5A3C);

        read_cfg();

        // short and misaligned writes are dropped
        frm = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
        write_cfg(0, 0);
        chk("R6", cfg_o === 48'h81F0_0F96_5A3C, "cfg after short write", cfg_o, 48'h81F0_0F96_5A3C);
        frm = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
        write_cfg(3, 0);
        chk("R6", cfg_o === 48'h81F0_0F96_5A3C, "cfg after misaligned write", cfg_o, 48'h81F0_0F96_5A3C);

        // unknown command
        begin
            int base;
            host_tx.delete();
            push_tx(8'h5A); push_tx(8'h12); push_tx(8'h34); push_tx(8'h56);
            base = up_rx.size();
            spi_run();
            cmp_bits("R12", "upward pass stream", up_rx, base, host_tx);
            exp_q.delete();
            for (int i = 0; i < 24; i++) exp_q.push_back(up_tx_mem[i]);
            cmp_bits("R12", "returned pass stream", host_rx, 8, exp_q);
            chk("R12", cfg_o === 48'h81F0_0F96_5A3C, "cfg after unknown command", cfg_o, 48'h81F0_0F96_5A3C);
        end

        // all-zero configuration check byte
        frm = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        write_cfg(0, 1);
        read_cfg();

        // top of stack
        top_tie = 1'b1;
        repeat (2) @(negedge clk);
        frm = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h01, 8'h23,
                8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF};
        write_cfg(0, 1);
        chk("R11", cfg_o === 48'hEFCD_AB89_6745, "top cfg after 2 frames", cfg_o, 48'hEFCD_AB89_6745);
        read_cfg();

        $display("Result: errors=%0d of %0d checks", errs + pc_err, checks + pc_checks);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs + pc_err + 1, checks + pc_checks + 1);
        $finish;
    end
endmodule